// File: doc/BRIEF.md
# Scatter-Gather Segment Queue for a Block-Storage DMA Engine

This block keeps an ordered queue of DMA segment descriptors and walks a simple word-request engine through them. Software programs it through a small 64-bit register window. For each segment it writes the segment's physical address and then a command word. The command word holds the segment length in 64-bit words minus one, a direction bit and an interrupt-suppress bit. The command write is the one that commits the descriptor to the queue.

The engine takes descriptors from the head of the queue in commit order. It issues one word request per cycle to a memory port and holds its place whenever the port applies back-pressure. When a segment without the suppress bit finishes, the block raises a one-cycle completion pulse and a sticky interrupt flag. A transfer of several segments sets the suppress bit on every segment except the last, so the whole transfer produces a single completion. A control write empties the queue, aborts the segment in progress and disables the block.

Top module: `sgq_top`

## Requirements
- R1: After reset the block is disabled, the queue holds 0 entries, `mem_req` is low and `irq` is low.
- R2: A write of 0 to the config register (offset 0x00) enables the block. A config write with bit 16 set disables it, discards every queued descriptor and aborts the segment in progress. No request is issued while the block is disabled.
- R3: A write to the command register (offset 0x18) commits one descriptor built from the address register (offset 0x10) and the command word. In the command word, bits 55:36 hold the length in 64-bit words minus one. A command write while the block is disabled creates no entry.
- R4: Descriptors are executed strictly in the order they were committed.
- R5: A segment of length field L issues exactly L+1 word requests. The first is at the segment's address, and each accepted request advances the address by 8.
- R6: Command bit 62 set means memory is read (`mem_we` = 0, data toward the card). Bit 62 clear means memory is written (`mem_we` = 1).
- R7: When the last word of a segment with command bit 60 clear is accepted, `done_pulse` is high for exactly the following cycle and `irq` becomes set. A segment with bit 60 set produces neither.
- R8: A command write while the queue holds DEPTH entries is dropped. It sets a sticky overflow flag, read back at config bit 9.
- R9: The address register keeps its last written value. A second command write with no new address write reuses that address. The address register reads back at offset 0x10.
- R10: A config read returns the queued entry count in bits 7:0, the enable state in bit 8, overflow in bit 9 and the interrupt flag in bit 10. Any config write clears bits 9 and 10.
- R11: While `mem_req` is high and `mem_ready` is low, the request and its address stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Word request to memory |
| mem_we | output | 1 | 1 = word written into memory, 0 = word read from memory |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| done_pulse | output | 1 | One-cycle completion of a segment that allows completion |
| irq | output | 1 | Sticky completion flag |

## Verification
The embedded properties check several rules on every cycle. A stalled request keeps its address. Each accepted word that is not the last one moves the address by 8. The completion pulse lasts one cycle. No request appears while the block is disabled. The queue is never pushed when full, and a clear leaves it empty. Other behaviour needs the bench's scenarios: commit order across segments, the exact word count per segment, direction decoding, suppression of completion on all but the last segment, overflow dropping, address reuse and the config read-back fields. The bench checks these by comparing every accepted request against a scoreboard and by counting completions.

// File: rtl/sgq_pkg.sv
package sgq_pkg;

    localparam int ADDR_W     = 64;
    localparam int LEN_W      = 20;
    localparam int LEN_LSB    = 36;
    localparam int DIR_BIT    = 62;
    localparam int NOIRQ_BIT  = 60;
    localparam int CLR_BIT    = 16;
    localparam int WORD_BYTES = 8;

    localparam logic [4:0] OFS_CFG = 5'h00;
    localparam logic [4:0] OFS_ADR = 5'h10;
    localparam logic [4:0] OFS_CMD = 5'h18;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              to_card;
        logic              no_irq;
    } seg_desc_t;

    function automatic seg_desc_t make_desc(input logic [ADDR_W-1:0] a,
                                            input logic [63:0] cmd);
        seg_desc_t d;
        d.addr    = a;
        d.len     = cmd[LEN_LSB +: LEN_W];
        d.to_card = cmd[DIR_BIT];
        d.no_irq  = cmd[NOIRQ_BIT];
        return d;
    endfunction

endpackage

// File: rtl/sgq_regs.sv
module sgq_regs
    import sgq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [4:0]       reg_addr,
    input  logic [63:0]      reg_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             full,
    input  logic             seg_done,
    output logic             enable,
    output logic             flush,
    output logic             push,
    output seg_desc_t        push_desc,
    output logic             irq_flag,
    output logic [63:0]      reg_rdata
);

    logic              cfg_wr, cmd_wr;
    logic [ADDR_W-1:0] addr_q;
    logic              en_q, ovf_q, irq_q;
    logic [7:0]        cnt8;

    assign cfg_wr = reg_wr && (reg_addr == OFS_CFG);
    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD) && en_q;
    assign flush  = cfg_wr && reg_wdata[CLR_BIT];
    assign push   = cmd_wr && !full;
    assign push_desc = make_desc(addr_q, reg_wdata);
    assign enable   = en_q;
    assign irq_flag = irq_q;
    assign cnt8     = 8'(count);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            en_q   <= 1'b0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_ADR)
                addr_q <= reg_wdata;
            if (cfg_wr) begin
                en_q  <= !reg_wdata[CLR_BIT];
                ovf_q <= 1'b0;
            end else if (cmd_wr && full) begin
                ovf_q <= 1'b1;
            end
            if (seg_done)
                irq_q <= 1'b1;
            else if (cfg_wr)
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CFG: reg_rdata = {53'd0, irq_q, ovf_q, en_q, cnt8};
            OFS_ADR: reg_rdata = addr_q;
            default: reg_rdata = '0;
        endcase
    end

    // R10: any config write clears the overflow flag by the next cycle
    a_r10_cfg_clears_ovf: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !ovf_q);

endmodule

// File: rtl/sgq_store.sv
module sgq_store
    import sgq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  seg_desc_t        push_desc,
    input  logic             pop,
    input  logic             flush,
    output seg_desc_t        head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    seg_desc_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_p, rd_p;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign head  = slots[rd_p];

    always_ff @(posedge clk) begin
        if (push && !flush)
            slots[wr_p] <= push_desc;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_p  <= '0;
            rd_p  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_p <= nxt(wr_p);
            if (pop)  rd_p <= nxt(rd_p);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: the register side never pushes into a full queue
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    // R4: the engine never takes from an empty queue
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);
    // R2: a clear leaves the queue empty
    a_r2_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/sgq_engine.sv
module sgq_engine
    import sgq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              flush,
    input  logic              empty,
    input  seg_desc_t         head,
    output logic              pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    output logic              seg_done
);

    logic              busy_q, to_card_q, no_irq_q, done_q;
    logic [ADDR_W-1:0] cur_q;
    logic [LEN_W-1:0]  left_q;
    logic              fire, last;

    assign pop  = enable && !flush && !busy_q && !empty;
    assign fire = busy_q && mem_ready;
    assign last = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            cur_q     <= '0;
            left_q    <= '0;
            to_card_q <= 1'b0;
            no_irq_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (flush) begin
                busy_q <= 1'b0;
            end else if (pop) begin
                busy_q    <= 1'b1;
                cur_q     <= head.addr;
                left_q    <= head.len;
                to_card_q <= head.to_card;
                no_irq_q  <= head.no_irq;
            end else if (fire) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= !no_irq_q;
                end else begin
                    cur_q  <= cur_q + ADDR_W'(WORD_BYTES);
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

    assign mem_req  = busy_q;
    assign mem_we   = !to_card_q;
    assign mem_addr = cur_q;
    assign seg_done = done_q;

    // R11: a stalled request holds its address
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && !flush) |=> (mem_req && $stable(mem_addr)));
    // R5: each accepted non-final word steps the address by one word
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && !last && !flush)
        |=> (mem_addr == $past(mem_addr) + 64'd8));
    // R7: completion is a single-cycle pulse
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        seg_done |=> !seg_done);
    // R2: no request while disabled
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !mem_req);

endmodule

// File: rtl/sgq_top.sv
module sgq_top
    import sgq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    input  logic        mem_ready,
    output logic        done_pulse,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             enable, flush, push, pop, empty, full, seg_done;
    logic [CNT_W-1:0] count;
    seg_desc_t        push_desc, head;

    sgq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .count(count), .full(full),
        .seg_done(seg_done), .enable(enable), .flush(flush), .push(push),
        .push_desc(push_desc), .irq_flag(irq), .reg_rdata(reg_rdata)
    );

    sgq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_desc(push_desc),
        .pop(pop), .flush(flush), .head(head), .count(count),
        .empty(empty), .full(full)
    );

    sgq_engine u_engine (
        .clk(clk), .rst(rst), .enable(enable), .flush(flush),
        .empty(empty), .head(head), .pop(pop), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .seg_done(seg_done)
    );

    assign done_pulse = seg_done;

    // R7: a completion always leaves the sticky flag set
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> ##1 irq);

endmodule

// File: tb/sgq_top_tb.sv
module sgq_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h0;
    logic [63:0] reg_wdata = 64'h0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, done_pulse, irq;
    logic [63:0] mem_addr;
    logic        mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    sgq_top #(.DEPTH(16)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .done_pulse(done_pulse), .irq(irq)
    );

    typedef struct {
        logic [63:0] a;
        logic        we;
    } word_t;

    word_t exp_q[$];
    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int exp_done = 0;
    int rmode = 0;          // 0 always ready, 1 alternate, 2 never
    logic tgl = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        tgl <= ~tgl;
        mem_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? tgl : 1'b0;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done_pulse) done_seen++;
            if (mem_req && mem_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 R5 unexpected request", mem_addr, 64'h0);
                end else begin
                    word_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R4 R5 address", mem_addr, e.a);
                    chk(mem_we == e.we, "R6 direction", {63'd0, mem_we},
                        {63'd0, e.we});
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // driver: program one descriptor and record its expected words
    task automatic seg(input logic [63:0] addr, input int words,
                       input bit to_card, input bit no_irq,
                       input bit new_addr, input bit accepted);
        logic [63:0] cmd;
        cmd = (64'(words - 1) << 36) | (64'(to_card) << 62)
            | (64'(no_irq) << 60);
        if (new_addr) wr(5'h10, addr);
        if (accepted) begin
            for (int i = 0; i < words; i++) begin
                word_t w;
                w.a = addr + 64'(8 * i);
                w.we = !to_card;
                exp_q.push_back(w);
            end
            if (!no_irq) exp_done++;
        end
        wr(5'h18, cmd);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !mem_req) break;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 words outstanding",
            64'(exp_q.size()), 64'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        summary();
    end

    initial begin
        logic [63:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, v);
        chk(v[7:0] == 0, "R1 count", {56'd0, v[7:0]}, 64'h0);
        chk(v[8] == 0, "R1 enable", {63'd0, v[8]}, 64'h0);
        chk(!mem_req, "R1 mem_req", {63'd0, mem_req}, 64'h0);
        chk(!irq, "R1 irq", {63'd0, irq}, 64'h0);

        // R3 command while disabled creates no entry
        seg(64'h100, 2, 0, 0, 1, 0);
        rd(5'h00, v);
        chk(v[7:0] == 0, "R3 disabled cmd ignored", {56'd0, v[7:0]}, 64'h0);

        // R2 enable
        wr(5'h00, 64'h0);
        rd(5'h00, v);
        chk(v[8] == 1, "R2 enable bit", {63'd0, v[8]}, 64'h1);

        // R4 R5 R7: three segments, only the last allows completion
        rmode = 0;
        seg(64'h1000, 4, 1, 1, 1, 1);
        seg(64'h8000, 1, 1, 1, 1, 1);
        seg(64'h20000, 2, 1, 0, 1, 1);
        wait_idle();
        chk(done_seen == exp_done, "R7 single completion",
            64'(done_seen), 64'(exp_done));
        chk(irq == 1, "R7 irq set", {63'd0, irq}, 64'h1);

        // R6 R11: memory-write segment under alternating back-pressure
        rmode = 1;
        seg(64'h3000, 3, 0, 0, 1, 1);
        wait_idle();
        chk(done_seen == exp_done, "R7 completion after stall",
            64'(done_seen), 64'(exp_done));

        // R9 address reuse and read-back
        rmode = 0;
        seg(64'h5000, 2, 1, 0, 1, 1);
        seg(64'h5000, 1, 0, 0, 0, 1);
        wait_idle();
        rd(5'h10, v);
        chk(v == 64'h5000, "R9 address read-back", v, 64'h5000);
        chk(done_seen == exp_done, "R7 completions",
            64'(done_seen), 64'(exp_done));

        // R10 config write clears irq bit
        rd(5'h00, v);
        chk(v[10] == 1, "R10 irq bit set", {63'd0, v[10]}, 64'h1);
        wr(5'h00, 64'h0);
        rd(5'h00, v);
        chk(v[10] == 0 && v[8] == 1, "R10 irq cleared, still enabled",
            {53'd0, v[10:0]}, 64'h100);

        // R8 overflow under full back-pressure
        rmode = 2;
        for (int k = 0; k < 17; k++)
            seg(64'h40000 + 64'(k * 64), 1, 1, 1, 1, 1);
        seg(64'h90000, 1, 1, 1, 1, 0);
        rd(5'h00, v);
        chk(v[7:0] == 16, "R8 count at full", {56'd0, v[7:0]}, 64'd16);
        chk(v[9] == 1, "R8 overflow flag", {63'd0, v[9]}, 64'h1);
        chk(mem_req && mem_addr == 64'h40000, "R11 stalled request held",
            mem_addr, 64'h40000);

        // R2 clear discards queue and in-flight segment
        wr(5'h00, 64'h1_0000);
        exp_q.delete();
        rmode = 0;
        rd(5'h00, v);
        chk(v[7:0] == 0 && v[8] == 0, "R2 cleared and disabled",
            {55'd0, v[8:0]}, 64'h0);
        chk(!mem_req, "R2 no request after clear", {63'd0, mem_req}, 64'h0);
        repeat (10) @(negedge clk);

        // R10 re-enable clears overflow; engine runs again
        wr(5'h00, 64'h0);
        rd(5'h00, v);
        chk(v[9] == 0, "R10 overflow cleared", {63'd0, v[9]}, 64'h0);
        seg(64'hA000, 3, 0, 0, 1, 1);
        wait_idle();
        chk(done_seen == exp_done, "R7 final completion",
            64'(done_seen), 64'(exp_done));

        summary();
    end

endmodule